// File: doc/BRIEF.md
# SIMD Lane Execution Mask Controller

This block keeps the active-lane mask of a wide SIMD unit and rewrites it as a scalar sequencer steps through structured divergent control flow. The mask has one bit per vector lane, and a lane executes only while its bit is 1. Each cycle the sequencer may issue one operation: open a conditional region, switch to its alternative arm, close it, build a loop exit set, close a loop iteration, or retire lanes. An operation carries a per-lane condition vector, two source indices and one destination index into a small file of saved masks, an immediate word and a per-lane 32-bit float word.

Saved masks are produced and consumed by save-then-combine steps (AND, OR, XOR, AND-NOT), so there is no predicate stack. Nesting depth is limited only by how many saved-mask entries the sequencer assigns. The block reports the mask together with two flags. One flag says no lane is active, so the sequencer can skip a region. The other says at least one lane is active. The block also reports the last saved mask it wrote, and it raises a one-cycle loop-back indication.

Top module: `lanemask_ctrl`

## Requirements
- R1: On reset the lane mask is all ones, every saved-mask entry and `save_out` are zero, `mask_zero` is 0, `mask_any` is 1 and `loop_take` is 0.
- R2: Operation codes are NOP=0, IF=1, ELSE=2, END=3, BREAK=4, IF_BREAK=5, ELSE_BREAK=6, LOOP=7, KILL_IMM=8, KILL_VEC=9. An operation takes effect at the clock edge where `op_valid` is 1. With `op_valid` 0, or with a code outside 1..9, no mask, saved entry or output changes.
- R3: IF with old mask M and condition C sets the mask to M AND C, and writes M XOR (M AND C) to entry `op_dst`. That value is the set of lanes that failed the condition.
- R4: ELSE with current mask M and S = entry `op_src_a` writes M to entry `op_dst`, and sets the mask to (M OR S) XOR M.
- R5: END sets the mask to M OR entry `op_src_a`, so no lane is cleared.
- R6: Three operations write entry `op_dst` and leave the mask unchanged. BREAK writes M OR entry `op_src_a`. IF_BREAK writes C OR entry `op_src_a`. ELSE_BREAK writes entry `op_src_b` OR entry `op_src_a`.
- R7: LOOP sets the mask to M AND NOT entry `op_src_a`. `loop_take` is 1 for the cycle after it exactly when that new mask is nonzero; otherwise `loop_take` is 0.
- R8: KILL_IMM clears the whole mask when bit 31 of `kill_imm` is 1, and changes nothing when that bit is 0.
- R9: KILL_VEC keeps lane i only if its float in `kill_val[32*i+31:32*i]` satisfies 0 <= value. Positive numbers, +0, -0 and +inf are kept. Negative numbers, -inf and every NaN (exponent all ones, fraction nonzero) are cleared. Lanes already at 0 stay 0.
- R10: In the same cycle the mask updates, `mask_zero` and `mask_any` describe the new mask.
- R11: The saved-mask file has 8 entries of 64 bits. A write becomes visible to reads by the next operation. `save_out` shows the value of the most recent write and holds it through operations that do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| op_src_a | input | 3 | First saved-mask read index |
| op_src_b | input | 3 | Second saved-mask read index |
| op_dst | input | 3 | Saved-mask write index |
| cond_vec | input | 64 | Per-lane condition |
| kill_imm | input | 32 | Immediate kill word |
| kill_val | input | 2048 | Per-lane 32-bit floats for KILL_VEC |
| lane_mask | output | 64 | Current active-lane mask |
| mask_zero | output | 1 | No lane active |
| mask_any | output | 1 | At least one lane active |
| save_out | output | 64 | Last saved mask written |
| loop_take | output | 1 | Loop-back request after LOOP |

## Verification
A corrupted saved-mask entry stays invisible until an END, ELSE or LOOP reads it. At that point the error shows on `lane_mask` one cycle after that operation. The bench therefore closes every region it opens and confirms that the mask returns to all ones. A wrong combine on IF or one of the break operations shows on `save_out` in the cycle right after the operation. Lane-level kill errors show in the cycle after KILL_VEC, and the bench places the signed-zero and NaN patterns in known lanes so that such errors fall on known bits.

// File: rtl/lanemask_pkg.sv
package lanemask_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_IF         = 4'd1,
        OP_ELSE       = 4'd2,
        OP_END        = 4'd3,
        OP_BREAK      = 4'd4,
        OP_IF_BREAK   = 4'd5,
        OP_ELSE_BREAK = 4'd6,
        OP_LOOP       = 4'd7,
        OP_KILL_IMM   = 4'd8,
        OP_KILL_VEC   = 4'd9
    } op_e;

    // Operations that only produce a saved mask and never touch the lane mask
    function automatic logic op_is_break(input logic [3:0] code);
        return (code == OP_BREAK) || (code == OP_IF_BREAK) || (code == OP_ELSE_BREAK);
    endfunction

    function automatic logic op_is_kill(input logic [3:0] code);
        return (code == OP_KILL_IMM) || (code == OP_KILL_VEC);
    endfunction

endpackage

// File: rtl/lanemask_kill_eval.sv
module lanemask_kill_eval #(
    parameter int LANES = 64,
    parameter int VAL_W = 32,
    parameter int EXP_W = 8
) (
    input  logic [LANES*VAL_W-1:0] vals,
    output logic [LANES-1:0]       keep
);
    localparam int FRAC_W = VAL_W - EXP_W - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [VAL_W-1:0]  w;
        logic              sgn;
        logic [EXP_W-1:0]  ex;
        logic [FRAC_W-1:0] fr;
        logic              is_nan;
        logic              is_zero;
        assign w       = vals[g*VAL_W +: VAL_W];
        assign sgn     = w[VAL_W-1];
        assign ex      = w[VAL_W-2 -: EXP_W];
        assign fr      = w[FRAC_W-1:0];
        assign is_nan  = (&ex) && (|fr);
        assign is_zero = (ex == '0) && (fr == '0);
        // 0 <= x : false for NaN, true for either signed zero or any non-negative value
        assign keep[g] = !is_nan && (!sgn || is_zero);
    end

endmodule

// File: rtl/lanemask_savefile.sv
module lanemask_savefile #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [LANES-1:0] rd_data_a,
    output logic [LANES-1:0] rd_data_b
);
    logic [LANES-1:0] ent_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                ent_q[e] <= wr_data;
            end
        end
    end

    assign rd_data_a = ent_q[rd_idx_a];
    assign rd_data_b = ent_q[rd_idx_b];

endmodule

// File: rtl/lanemask_step.sv
module lanemask_step
    import lanemask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             valid,
    input  logic [3:0]       code,
    input  logic [LANES-1:0] mask,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] src_a,
    input  logic [LANES-1:0] src_b,
    input  logic [LANES-1:0] keep,
    input  logic             imm_kill,
    output logic [LANES-1:0] nxt_mask,
    output logic             wr_en,
    output logic [LANES-1:0] wr_data,
    output logic             loop_req
);
    logic [LANES-1:0] and_res;
    logic [LANES-1:0] or_res;
    logic [LANES-1:0] andn_res;

    assign and_res  = mask & cond;
    assign or_res   = mask | src_a;
    assign andn_res = mask & ~src_a;

    always_comb begin
        nxt_mask = mask;
        wr_en    = 1'b0;
        wr_data  = '0;
        loop_req = 1'b0;
        if (valid) begin
            case (op_e'(code))
                OP_IF: begin
                    nxt_mask = and_res;
                    wr_en    = 1'b1;
                    wr_data  = and_res ^ mask;
                end
                OP_ELSE: begin
                    nxt_mask = or_res ^ mask;
                    wr_en    = 1'b1;
                    wr_data  = mask;
                end
                OP_END: nxt_mask = or_res;
                OP_BREAK: begin
                    wr_en   = 1'b1;
                    wr_data = or_res;
                end
                OP_IF_BREAK: begin
                    wr_en   = 1'b1;
                    wr_data = cond | src_a;
                end
                OP_ELSE_BREAK: begin
                    wr_en   = 1'b1;
                    wr_data = src_b | src_a;
                end
                OP_LOOP: begin
                    nxt_mask = andn_res;
                    loop_req = |andn_res;
                end
                OP_KILL_IMM: if (imm_kill) nxt_mask = '0;
                OP_KILL_VEC: nxt_mask = mask & keep;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lanemask_ctrl.sv
module lanemask_ctrl
    import lanemask_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int SAVE_DEPTH = 8,
    parameter int VAL_W      = 32,
    parameter int EXP_W      = 8,
    localparam int IDX_W     = $clog2(SAVE_DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic [3:0]             op_code,
    input  logic [IDX_W-1:0]       op_src_a,
    input  logic [IDX_W-1:0]       op_src_b,
    input  logic [IDX_W-1:0]       op_dst,
    input  logic [LANES-1:0]       cond_vec,
    input  logic [VAL_W-1:0]       kill_imm,
    input  logic [LANES*VAL_W-1:0] kill_val,
    output logic [LANES-1:0]       lane_mask,
    output logic                   mask_zero,
    output logic                   mask_any,
    output logic [LANES-1:0]       save_out,
    output logic                   loop_take
);
    logic [LANES-1:0] mask_q, save_q;
    logic             zero_q, any_q, loop_q;
    logic [LANES-1:0] rd_a, rd_b, keep, nxt_mask, wr_data;
    logic             wr_en, loop_req;

    lanemask_savefile #(.LANES(LANES), .DEPTH(SAVE_DEPTH), .IDX_W(IDX_W)) u_file (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(op_dst), .wr_data(wr_data),
        .rd_idx_a(op_src_a), .rd_idx_b(op_src_b),
        .rd_data_a(rd_a), .rd_data_b(rd_b)
    );

    lanemask_kill_eval #(.LANES(LANES), .VAL_W(VAL_W), .EXP_W(EXP_W)) u_kill (
        .vals(kill_val), .keep(keep)
    );

    lanemask_step #(.LANES(LANES)) u_step (
        .valid(op_valid), .code(op_code), .mask(mask_q), .cond(cond_vec),
        .src_a(rd_a), .src_b(rd_b), .keep(keep), .imm_kill(kill_imm[VAL_W-1]),
        .nxt_mask(nxt_mask), .wr_en(wr_en), .wr_data(wr_data), .loop_req(loop_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            zero_q <= 1'b0;
            any_q  <= 1'b1;
            save_q <= '0;
            loop_q <= 1'b0;
        end else begin
            mask_q <= nxt_mask;
            zero_q <= (nxt_mask == '0);
            any_q  <= (nxt_mask != '0);
            loop_q <= loop_req;
            if (wr_en) save_q <= wr_data;
        end
    end

    assign lane_mask = mask_q;
    assign mask_zero = zero_q;
    assign mask_any  = any_q;
    assign save_out  = save_q;
    assign loop_take = loop_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(lane_mask) && $stable(save_out)); // R2
    AST_IF_NO_NEW_LANE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_IF) |=> ((lane_mask & ~$past(lane_mask)) == '0)); // R3
    AST_IF_SPLIT_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_IF) |=> ((lane_mask & save_out) == '0)); // R3
    AST_END_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_END) |=> ((~lane_mask & $past(lane_mask)) == '0)); // R5
    AST_BREAK_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_break(op_code)) |=> $stable(lane_mask)); // R6
    AST_LOOP_LIVE: assert property (@(posedge clk) disable iff (rst)
        loop_take |-> (lane_mask != '0) && $past(op_valid && op_code == OP_LOOP)); // R7
    AST_KILL_NO_NEW_LANE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_kill(op_code)) |=> ((lane_mask & ~$past(lane_mask)) == '0)); // R9
    AST_FLAGS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (mask_zero == (lane_mask == '0)) && (mask_any != mask_zero)); // R10

endmodule

// File: tb/lanemask_ctrl_tb_top.sv
module lanemask_ctrl_tb_top;
    localparam int L = 64;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst;
    logic           op_valid;
    logic [3:0]     op_code;
    logic [2:0]     op_src_a, op_src_b, op_dst;
    logic [L-1:0]   cond_vec;
    logic [W-1:0]   kill_imm;
    logic [L*W-1:0] kill_val;
    logic [L-1:0]   lane_mask, save_out;
    logic           mask_zero, mask_any, loop_take;

    lanemask_ctrl dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
        .cond_vec(cond_vec), .kill_imm(kill_imm), .kill_val(kill_val),
        .lane_mask(lane_mask), .mask_zero(mask_zero), .mask_any(mask_any),
        .save_out(save_out), .loop_take(loop_take)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [L-1:0] m_mask, m_save;
    logic [L-1:0] m_file [8];
    logic         m_loop;

    task automatic chk(input string req, input string what, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "lane_mask", lane_mask, m_mask);
        chk(req, "save_out", save_out, m_save);
        chk(req, "mask_zero", L'(mask_zero), L'(m_mask == '0));
        chk(req, "mask_any", L'(mask_any), L'(m_mask != '0));
        chk(req, "loop_take", L'(loop_take), L'(m_loop));
    endtask

    function automatic logic lane_keep(input logic [W-1:0] v);
        logic nan, zero;
        nan  = (v[30:23] == 8'hFF) && (v[22:0] != '0);
        zero = (v[30:0] == '0);
        return !nan && (!v[31] || zero);
    endfunction

    // Issue one operation, update the model from the requirement formulas, check the outputs
    task automatic op(input string req, input logic vld, input logic [3:0] code,
                      input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] d,
                      input logic [L-1:0] c, input logic [W-1:0] imm);
        logic [L-1:0] a, b, nm, keep;
        logic         we;
        logic [L-1:0] wd;
        a = m_file[sa]; b = m_file[sb]; nm = m_mask; we = 1'b0; wd = '0;
        for (int i = 0; i < L; i++) keep[i] = lane_keep(kill_val[i*W +: W]);
        m_loop = 1'b0;
        if (vld) begin
            case (code)
                4'd1: begin nm = m_mask & c; we = 1; wd = m_mask & ~c; end
                4'd2: begin nm = (m_mask | a) ^ m_mask; we = 1; wd = m_mask; end
                4'd3: nm = m_mask | a;
                4'd4: begin we = 1; wd = m_mask | a; end
                4'd5: begin we = 1; wd = c | a; end
                4'd6: begin we = 1; wd = b | a; end
                4'd7: begin nm = m_mask & ~a; m_loop = (nm != '0); end
                4'd8: if (imm[31]) nm = '0;
                4'd9: nm = m_mask & keep;
                default: ;
            endcase
        end
        m_mask = nm;
        if (we) begin m_file[d] = wd; m_save = wd; end
        @(negedge clk);
        op_valid = vld; op_code = code; op_src_a = sa; op_src_b = sb; op_dst = d;
        cond_vec = c; kill_imm = imm;
        @(negedge clk);
        op_valid = 1'b0;
        chk_all(req);
    endtask

    localparam logic [L-1:0] ONES = '1;

    task automatic t_reset();
        chk_all("R1");
        // each saved entry reads as zero: END with any entry leaves mask at all ones
        op("R1", 1, 4'd3, 3'd7, 3'd0, 3'd0, '0, '0);
    endtask

    task automatic t_if_else_end();
        logic [L-1:0] c1 = 64'h0F0F_00FF_F0F0_1234;
        op("R3", 1, 4'd1, 3'd0, 3'd0, 3'd1, c1, '0);
        chk("R3", "failed lanes", save_out, ~c1);
        op("R4", 1, 4'd2, 3'd1, 3'd0, 3'd2, '0, '0);
        chk("R4", "else arm", lane_mask, ~c1);
        op("R5", 1, 4'd3, 3'd2, 3'd0, 3'd0, '0, '0);
        chk("R5", "rejoin", lane_mask, ONES);
    endtask

    task automatic t_nested();
        op("R3", 1, 4'd1, 3'd0, 3'd0, 3'd3, 64'hFFFF_0000_FFFF_0000, '0);
        op("R3", 1, 4'd1, 3'd0, 3'd0, 3'd4, 64'hFF00_FF00_FF00_FF00, '0);
        chk("R3", "nested mask", lane_mask, 64'hFF00_0000_FF00_0000);
        op("R11", 1, 4'd3, 3'd4, 3'd0, 3'd0, '0, '0);
        op("R5", 1, 4'd3, 3'd3, 3'd0, 3'd0, '0, '0);
        chk("R5", "nested rejoin", lane_mask, ONES);
    endtask

    task automatic t_all_fail();
        op("R10", 1, 4'd1, 3'd0, 3'd0, 3'd1, '0, '0);
        chk("R10", "zero flag", L'(mask_zero), L'(1));
        op("R10", 1, 4'd3, 3'd1, 3'd0, 3'd0, '0, '0);
    endtask

    task automatic t_loop_breaks();
        logic [L-1:0] x = 64'h8000_0000_0000_0001;
        op("R6", 1, 4'd5, 3'd5, 3'd0, 3'd5, x, '0);
        op("R7", 1, 4'd7, 3'd5, 3'd0, 3'd0, '0, '0);
        chk("R7", "loop back", L'(loop_take), L'(1));
        op("R6", 1, 4'd4, 3'd5, 3'd0, 3'd6, '0, '0);
        op("R6", 1, 4'd6, 3'd6, 3'd5, 3'd7, '0, '0);
        op("R7", 1, 4'd7, 3'd7, 3'd0, 3'd0, '0, '0);
        chk("R7", "loop exit", L'(loop_take), L'(0));
        op("R7", 1, 4'd3, 3'd6, 3'd0, 3'd0, '0, '0);
    endtask

    task automatic t_kill_imm();
        op("R8", 1, 4'd8, 3'd0, 3'd0, 3'd0, '0, 32'h7FFF_FFFF);
        op("R8", 1, 4'd8, 3'd0, 3'd0, 3'd0, '0, 32'h8000_0000);
        chk("R8", "killed all", lane_mask, '0);
        op("R8", 1, 4'd3, 3'd6, 3'd0, 3'd0, '0, '0);
    endtask

    task automatic t_kill_vec();
        logic [W-1:0] pat [8] = '{32'h3F80_0000, 32'hBF80_0000, 32'h0000_0000, 32'h8000_0000,
                                 32'h7FC0_0000, 32'h7F80_0000, 32'hFF80_0000, 32'hFFC0_0000};
        for (int i = 0; i < L; i++) kill_val[i*W +: W] = pat[i % 8];
        op("R9", 1, 4'd9, 3'd0, 3'd0, 3'd0, '0, '0);
        chk("R9", "lane pattern", lane_mask, {8{8'b0010_1101}});
        op("R9", 1, 4'd3, 3'd6, 3'd0, 3'd0, '0, '0);
        op("R9", 1, 4'd1, 3'd0, 3'd0, 3'd1, 64'h0000_0000_FFFF_FFFF, '0);
        op("R9", 1, 4'd9, 3'd0, 3'd0, 3'd0, '0, '0);
        op("R9", 1, 4'd3, 3'd6, 3'd0, 3'd0, '0, '0);
    endtask

    task automatic t_ignored();
        logic [L-1:0] s0 = save_out;
        op("R2", 0, 4'd8, 3'd0, 3'd0, 3'd0, '0, 32'hFFFF_FFFF);
        op("R2", 0, 4'd1, 3'd0, 3'd0, 3'd2, '0, '0);
        op("R2", 1, 4'd15, 3'd0, 3'd0, 3'd2, '0, '0);
        chk("R2", "save held", save_out, s0);
        op("R11", 1, 4'd3, 3'd2, 3'd0, 3'd0, '0, '0);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; op_src_a = '0; op_src_b = '0;
        op_dst = '0; cond_vec = '0; kill_imm = '0; kill_val = '0;
        m_mask = ONES; m_save = '0; m_loop = 1'b0;
        for (int i = 0; i < 8; i++) m_file[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_if_else_end();
        t_nested();
        t_all_fail();
        t_loop_breaks();
        t_kill_imm();
        t_kill_vec();
        t_ignored();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule